// File: doc/BRIEF.md
# Stepper Motor Step Sequencer

This block turns a single move command into a timed series of coil patterns for a four-coil stepper motor. The command word carries a direction flag in its top bit and a step count in the bits below it. Once accepted, the block issues the requested steps one at a time, separated by a fixed dwell so the armature can settle. It then pulses `done` and keeps the coils at the last position until the next command arrives.

Two drive styles are offered. In full-step mode two coils are always energized, and the pattern advances by a one-bit rotation of an 8-bit position byte. In half-step mode the block walks an eight-entry sequence that alternates single-coil and two-coil patterns. The mode input is sampled when a command is accepted. When the mode input returns to full-step while the block is idle on a single-coil pattern, the position moves forward to the next two-coil pattern.

Top module: `stepper_seq`

## Requirements
- R1: After reset, `coil` is 4'h3 (position byte 33H), and `busy` and `done` are low.
- R2: In full-step mode with command bit 15 set (right), each step rotates the position byte one bit right: coil runs 3, 9, C, 6, 3 and repeats. Bits 14..0 give the step count. In full-step mode exactly two coil bits are set while busy.
- R3: In full-step mode with command bit 15 clear (left), each step rotates the position byte one bit left: coil runs 3, 6, C, 9, 3.
- R4: In half-step mode, left steps go forward through the byte sequence 11H, 33H, 22H, 66H, 44H, CCH, 88H, 99H (coil 1, 3, 2, 6, 4, C, 8, 9, wrapping around), and right steps go backward through it. The mode is taken from `half_mode` in the accept cycle, and changes to it while busy have no effect on the command. `coil` always has one or two bits set.
- R5: The first step appears on `coil` one cycle after the accept edge. Each later step follows the previous one by exactly DWELL_CYCLES cycles.
- R6: A command with a count of 0 raises `done` for one cycle, starting the cycle after the accept. `busy` stays low and `coil` does not change.
- R7: `cmd_valid` while `busy` is high is ignored. The running command completes with its own count and direction.
- R8: While idle, if `half_mode` is low and the position is a single-coil pattern, the position advances one entry forward in the half-step sequence on the next edge, to the following two-coil pattern.
- R9: `busy` is high from the cycle after a nonzero accept until `done` rises. `done` is a one-cycle pulse that appears DWELL_CYCLES cycles after the last step, and `done` and `busy` are never high together.
- R10: While idle, and outside the R8 snap, `coil` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_word | input | CNT_W+1 | Bit CNT_W = direction (1 right), lower bits = step count |
| half_mode | input | 1 | 1 selects half-step mode, 0 full-step mode |
| coil | output | 4 | Coil drive, lower nibble of the position byte |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse when a move finishes |

## Verification
Every result has a fixed latency. A command strobed in one cycle is accepted on the next rising edge. The first coil change is visible one cycle after that edge, each later change comes DWELL_CYCLES cycles after the one before, and `done` follows the last step by another DWELL_CYCLES. A zero-count `done` and the full-step snap each appear one cycle after their cause. The bench drives inputs on falling edges. It advances a behavioural model on each rising edge, using byte rotation for full steps and a sequence lookup for half steps, and compares `coil`, `busy` and `done` on every falling edge. Directed checks count falling edges from the stimulus to each transition and compare the count with these latencies.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int NUM_PHASES = 8;
  typedef logic [$clog2(NUM_PHASES)-1:0] phase_t;
  localparam phase_t HOME_PHASE = phase_t'(1);

  // position byte for each entry of the eight-phase sequence
  function automatic logic [7:0] phase_byte(phase_t i);
    case (i)
      3'd0: phase_byte = 8'h11;
      3'd1: phase_byte = 8'h33;
      3'd2: phase_byte = 8'h22;
      3'd3: phase_byte = 8'h66;
      3'd4: phase_byte = 8'h44;
      3'd5: phase_byte = 8'hCC;
      3'd6: phase_byte = 8'h88;
      default: phase_byte = 8'h99;
    endcase
  endfunction

  function automatic logic [3:0] coil_bits(phase_t i);
    logic [7:0] b;
    b = phase_byte(i);
    coil_bits = b[3:0];
  endfunction
endpackage

// File: rtl/stepper_step_timer.sv
module stepper_step_timer #(
  parameter int CNT_W        = 15,
  parameter int DWELL_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CNT_W:0]   cmd_word,
  input  logic             half_mode,
  output logic             busy,
  output logic             done,
  output logic             step_en,
  output logic             dir_right,
  output logic             half_q
);
  localparam int TW = $clog2(DWELL_CYCLES + 1);
  localparam logic [TW-1:0] RELOAD = TW'(DWELL_CYCLES - 1);

  logic [TW-1:0]    timer;
  logic [CNT_W-1:0] remain;
  logic             accept;
  logic             cnt_zero;
  logic             tick;

  assign accept   = cmd_valid && !busy;
  assign cnt_zero = (cmd_word[CNT_W-1:0] == '0);
  assign tick     = busy && (timer == '0);
  assign step_en  = tick && (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      timer     <= '0;
      remain    <= '0;
      dir_right <= 1'b0;
      half_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        dir_right <= cmd_word[CNT_W];
        half_q    <= half_mode;
        remain    <= cmd_word[CNT_W-1:0];
        timer     <= '0;
        busy      <= !cnt_zero;
        done      <= cnt_zero;
      end else if (busy) begin
        if (timer != '0) begin
          timer <= timer - 1'b1;
        end else if (remain != '0) begin
          remain <= remain - 1'b1;
          timer  <= RELOAD;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_ZERO_CMD: assert property (@(posedge clk) disable iff (rst)
    (accept && cnt_zero) |=> (done && !busy)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> (remain <= $past(remain) && $stable(dir_right) && $stable(half_q))); // R7
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    timer <= RELOAD); // R5
endmodule

// File: rtl/stepper_phase_ctrl.sv
module stepper_phase_ctrl
  import stepper_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_en,
  input  logic       dir_right,
  input  logic       half_q,
  input  logic       idle,
  input  logic       half_mode,
  output logic [3:0] coil
);
  phase_t idx;
  phase_t idx_nxt;
  phase_t stride;

  assign stride = half_q ? phase_t'(1) : phase_t'(2);

  always_comb begin
    idx_nxt = idx;
    if (step_en) begin
      if (dir_right) idx_nxt = idx - stride;
      else           idx_nxt = idx + stride;
    end else if (idle && !half_mode && !idx[0]) begin
      idx_nxt = idx + phase_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= HOME_PHASE;
      coil <= coil_bits(HOME_PHASE);
    end else begin
      idx  <= idx_nxt;
      coil <= coil_bits(idx_nxt);
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(idle) && $past(half_mode)) |-> $stable(coil)); // R10
  AST_FULL_TWO_COIL: assert property (@(posedge clk) disable iff (rst)
    (!idle && !half_q) |-> ($countones(coil) == 2)); // R2
  AST_COIL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ($countones(coil) == 1 || $countones(coil) == 2)); // R4
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
    step_en |=> !$stable(coil)); // R5
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq #(
  parameter int CNT_W        = 15,
  parameter int DWELL_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CNT_W:0]   cmd_word,
  input  logic             half_mode,
  output logic [3:0]       coil,
  output logic             busy,
  output logic             done
);
  logic step_en;
  logic dir_right;
  logic half_q;

  stepper_step_timer #(
    .CNT_W       (CNT_W),
    .DWELL_CYCLES(DWELL_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_word (cmd_word),
    .half_mode(half_mode),
    .busy     (busy),
    .done     (done),
    .step_en  (step_en),
    .dir_right(dir_right),
    .half_q   (half_q)
  );

  stepper_phase_ctrl u_phase (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .dir_right(dir_right),
    .half_q   (half_q),
    .idle     (!busy),
    .half_mode(half_mode),
    .coil     (coil)
  );
endmodule

// File: tb/stepper_seq_test.sv
module stepper_seq_test;
  localparam int DW = 4;
  localparam int CW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [CW:0]   cmd_word = '0;
  logic          half_mode = 1'b0;
  logic [3:0]    coil;
  logic          busy;
  logic          done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  stepper_seq #(.CNT_W(CW), .DWELL_CYCLES(DW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .half_mode(half_mode), .coil(coil), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  logic [7:0] m_pat;
  bit m_busy, m_done, m_dir, m_half;
  int m_rem, m_gap;

  function automatic logic [7:0] seq_at(int k);
    case (k)
      0: return 8'h11; 1: return 8'h33; 2: return 8'h22; 3: return 8'h66;
      4: return 8'h44; 5: return 8'hCC; 6: return 8'h88; default: return 8'h99;
    endcase
  endfunction

  function automatic int seq_pos(logic [7:0] p);
    for (int k = 0; k < 8; k++) if (seq_at(k) == p) return k;
    return 0;
  endfunction

  function automatic logic [7:0] advance(logic [7:0] p, bit right, bit half);
    int k;
    if (!half) return right ? {p[0], p[7:1]} : {p[6:0], p[7]};
    k = seq_pos(p);
    return right ? seq_at((k + 7) % 8) : seq_at((k + 1) % 8);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pat = 8'h33; m_busy = 0; m_done = 0; m_rem = 0; m_gap = 0;
    end else begin
      m_done = 0;
      if (!m_busy && !half_mode && (m_pat == 8'h11 || m_pat == 8'h22 ||
          m_pat == 8'h44 || m_pat == 8'h88))
        m_pat = seq_at((seq_pos(m_pat) + 1) % 8);
      if (m_busy) begin
        m_gap--;
        if (m_gap == 0) begin
          if (m_rem > 0) begin
            m_pat = advance(m_pat, m_dir, m_half);
            m_rem--;
            m_gap = DW;
          end else begin
            m_busy = 0;
            m_done = 1;
          end
        end
      end else if (cmd_valid) begin
        if (cmd_word[CW-1:0] == 0) m_done = 1;
        else begin
          m_busy = 1; m_rem = int'(cmd_word[CW-1:0]); m_gap = 1;
          m_dir = cmd_word[CW]; m_half = half_mode;
        end
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      tests++;
      if (coil !== m_pat[3:0] || busy !== m_busy || done !== m_done) begin
        fails++;
        $display("FAIL R9 cycle %0d: coil/busy/done act=%h/%b/%b exp=%h/%b/%b",
                 cyc, coil, busy, done, m_pat[3:0], m_busy, m_done);
      end
    end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired, run hung");
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(bit right, int n);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {right, CW'(n)};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int k;
    repeat (4) @(negedge clk);
    chk("R1 coil", coil, 4'h3);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    rst = 1'b0;

    // R2: five right full steps 3->9->C->6->3->9
    send(1, 5); wait_done();
    chk("R2 final coil", coil, 4'h9);

    // R3: three left full steps 9->3->6->C
    send(0, 3); wait_done();
    chk("R3 final coil", coil, 4'hC);

    // R5 / R9: timing of steps and done
    send(1, 3);
    chk("R5 no move at accept+0", coil, 4'hC);
    chk("R9 busy after accept", busy, 1);
    @(negedge clk);
    chk("R5 first step at accept+1", coil, 4'h6);
    k = 0;
    while (coil == 4'h6) begin @(negedge clk); k++; end
    chk("R5 step spacing", k, DW);
    chk("R2 second step", coil, 4'h3);
    while (coil == 4'h3) @(negedge clk);
    k = 0;
    while (!done) begin @(negedge clk); k++; end
    chk("R9 done delay after last step", k, DW);
    chk("R9 busy low at done", busy, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R2 coil after 3 right", coil, 4'h9);

    // R6: zero count
    send(1, 0);
    chk("R6 done", done, 1);
    chk("R6 busy", busy, 0);
    chk("R6 coil", coil, 4'h9);
    @(negedge clk);
    chk("R6 done pulse", done, 0);

    // R7: command and mode change during busy ignored
    send(0, 2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = {1'b1, CW'(7)}; half_mode = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; half_mode = 1'b0;
    wait_done();
    chk("R7 coil after 2 left", coil, 4'h6);
    repeat (3) @(negedge clk);
    chk("R7 stays idle", busy, 0);

    // R10: hold while idle
    repeat (10) @(negedge clk);
    chk("R10 hold", coil, 4'h6);

    // R4: half-step forward and backward
    half_mode = 1'b1;
    send(0, 8); wait_done();
    chk("R4 eight half steps left wrap", coil, 4'h6);
    send(1, 3); wait_done();
    chk("R4 three half steps right", coil, 4'h1);
    repeat (5) @(negedge clk);
    chk("R10 hold in half mode", coil, 4'h1);

    // R8: snap to following two-coil pattern
    @(negedge clk); half_mode = 1'b0;
    @(negedge clk);
    chk("R8 snap", coil, 4'h3);
    send(0, 1); wait_done();
    chk("R3 step after snap", coil, 4'h6);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule